// File: doc/BRIEF.md
# Gated Phase-Frequency Detector

This block compares two single-cycle strobes, one from the divided reference and one from the divided oscillator of a synthesizer channel. It produces logic-level pump-up, pump-down and high-impedance indications for an external charge pump. Each strobe arms its own error flag. When both flags are armed, they are cleared together one clock later. So when the loop is locked, only minimum-width pulses leave the block. A slope-select input swaps the meaning of up and down to suit oscillators whose frequency falls with control voltage. A force input parks the pump outputs in high impedance without losing the internal error state.

A power-down request for the channel does not take effect at once. It waits until the pump is idle (in high impedance), so the loop never sees a frequency step. Only then does it drop the divider enable and hold the detector clear. A shared-disable flag tells the common reference path that this channel and its peer both want to be off.

A lock monitor counts consecutive error pulses whose width stays within a small threshold and declares lock after a set number of them. The lock output is high while locked and dips low for the duration of each pump pulse. The first pulse wider than the threshold clears lock.

Top module: `pfd_gated`

## Requirements
- R1: With `pos_slope`=1, a `ref_stb` pulse drives `pump_up`=1 from the next clock and a `vco_stb` pulse drives `pump_dn`=1 from the next clock.
- R2: Once both error flags are set, both are cleared at the following clock. A pair of strobes arriving together therefore gives a one-clock pulse on both outputs.
- R3: A repeated strobe on the side already armed changes nothing; a single strobe on the other side still clears both one clock after they meet.
- R4: With `pos_slope`=0, the error flag armed by `vco_stb` appears on `pump_up` and the one armed by `ref_stb` appears on `pump_dn`.
- R5: While `force_hiz`=1, `pump_up`=`pump_dn`=0 and `pump_hiz`=1. An armed error flag is kept and shows again once `force_hiz` returns to 0.
- R6: `pump_hiz`=1 whenever no error flag is armed.
- R7: With `pd_req`=1, `div_en` falls only at the clock after one on which both error flags were clear. While a pulse is in progress, `div_en` stays 1.
- R8: While powered down, strobes are ignored and the pump stays in high impedance. Dropping `pd_req` sets `div_en` back to 1 at the next clock, and strobes work again.
- R9: `shared_off` is 1 exactly when this channel is powered down and `peer_pd_req`=1.
- R10: `lock_det` rises after `LOCK_CYCLES` (default 8) consecutive pulses, each no more than `WIDTH_THRESH` (default 2) clocks wide.
- R11: While locked, `lock_det` is 0 during each pump pulse and returns to 1 when the pulse ends.
- R12: A pulse lasting more than `WIDTH_THRESH` clocks clears lock and restarts the count.
- R13: Synchronous reset gives `pump_up`=`pump_dn`=0, `pump_hiz`=1, `lock_det`=0, `div_en`=1 and `shared_off`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | 1 | Divided reference strobe, one clock wide |
| vco_stb | input | 1 | Divided oscillator strobe, one clock wide |
| pos_slope | input | 1 | 1: oscillator frequency rises with control voltage; 0: swap up and down |
| force_hiz | input | 1 | Force the pump outputs to high impedance |
| pd_req | input | 1 | Power-down request for this channel |
| peer_pd_req | input | 1 | Power-down request of the other channel |
| pump_up | output | 1 | Pump source indication |
| pump_dn | output | 1 | Pump sink indication |
| pump_hiz | output | 1 | Pump in high impedance |
| lock_det | output | 1 | Lock indication, low during pump pulses |
| div_en | output | 1 | Enable for this channel's divider |
| shared_off | output | 1 | Both channels are down; the reference path may stop |

## Verification
The bench builds the block with its defaults: a lock count of 8 and a width threshold of 2 clocks. With these values, acquiring lock takes only a few dozen clocks, and a three-clock pulse is enough to break it. The bench can therefore step through acquisition, the low dips while locked, and loss of lock. A table of strobe pairs covers both slope settings and a forced high-impedance state. Directed sequences then place a power-down request in the middle of a pulse, so the deferral cycle can be counted exactly.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_err_t;

    // Map internal error flags to pump direction according to oscillator slope.
    function automatic pfd_err_t orient(pfd_err_t e, logic pos_slope);
        pfd_err_t o;
        if (pos_slope) begin
            o = e;
        end else begin
            o.up = e.dn;
            o.dn = e.up;
        end
        return o;
    endfunction

    function automatic logic err_active(pfd_err_t e);
        return e.up | e.dn;
    endfunction

endpackage

// File: rtl/pfd_detector_core.sv
`timescale 1ns/1ps
module pfd_detector_core
    import pfd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     ref_stb,
    input  logic     vco_stb,
    output pfd_err_t err_q
);

    logic meet;
    assign meet = err_q.up & err_q.dn;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            err_q <= '0;
        end else if (meet) begin
            err_q <= '0;
        end else begin
            err_q.up <= err_q.up | ref_stb;
            err_q.dn <= err_q.dn | vco_stb;
        end
    end

    // R2: overlapping flags are removed one clock after they meet
    assert_overlap_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (err_q.up && err_q.dn) |=> (!err_q.up && !err_q.dn));

endmodule

// File: rtl/pfd_pd_gate.sv
`timescale 1ns/1ps
module pfd_pd_gate (
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    input  logic peer_pd_req,
    input  logic pump_idle,
    output logic pd_active,
    output logic div_en,
    output logic shared_off
);

    logic pd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q <= 1'b0;
        end else if (!pd_req) begin
            pd_q <= 1'b0;
        end else if (pump_idle) begin
            pd_q <= 1'b1;
        end
    end

    assign pd_active  = pd_q;
    assign div_en     = ~pd_q;
    assign shared_off = pd_q & peer_pd_req;

    // R7: power-down only enters after an idle pump instant
    assert_pd_deferred_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_q) |-> $past(pump_idle));

endmodule

// File: rtl/pfd_lock_monitor.sv
`timescale 1ns/1ps
module pfd_lock_monitor #(
    parameter int LOCK_CYCLES  = 8,
    parameter int WIDTH_THRESH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic active,
    output logic lock_o
);

    localparam int WCNT_W = $clog2(WIDTH_THRESH + 2);
    localparam int GOOD_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [WCNT_W-1:0] THR  = WCNT_W'(WIDTH_THRESH);
    localparam logic [GOOD_W-1:0] LAST = GOOD_W'(LOCK_CYCLES - 1);

    logic [WCNT_W-1:0] wcnt_q;
    logic [GOOD_W-1:0] good_q;
    logic              locked_q;
    logic              over;
    logic              pulse_end;

    assign over      = active && (wcnt_q >= THR);
    assign pulse_end = !active && (wcnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wcnt_q   <= '0;
            good_q   <= '0;
            locked_q <= 1'b0;
        end else begin
            if (active) begin
                if (wcnt_q <= THR) begin
                    wcnt_q <= wcnt_q + 1'b1;
                end
            end else begin
                wcnt_q <= '0;
            end

            if (over) begin
                good_q   <= '0;
                locked_q <= 1'b0;
            end else if (pulse_end && (wcnt_q <= THR)) begin
                if (good_q >= LAST) begin
                    locked_q <= 1'b1;
                end else begin
                    good_q <= good_q + 1'b1;
                end
            end
        end
    end

    assign lock_o = locked_q & ~active;

    // R12: a pulse over the width threshold clears lock
    assert_wide_unlocks_R12: assert property (@(posedge clk) disable iff (rst)
        (active && !clear && (wcnt_q >= THR)) |=> !locked_q);

    // R10: lock only rises at the end of a narrow pulse
    assert_lock_on_pulse_end_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> $past(pulse_end));

endmodule

// File: rtl/pfd_gated.sv
`timescale 1ns/1ps
module pfd_gated
    import pfd_pkg::*;
#(
    parameter int LOCK_CYCLES  = 8,
    parameter int WIDTH_THRESH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_stb,
    input  logic vco_stb,
    input  logic pos_slope,
    input  logic force_hiz,
    input  logic pd_req,
    input  logic peer_pd_req,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_hiz,
    output logic lock_det,
    output logic div_en,
    output logic shared_off
);

    pfd_err_t err_q;
    pfd_err_t drive;
    logic     pd_active;
    logic     idle;

    pfd_detector_core u_core (
        .clk     (clk),
        .rst     (rst),
        .flush   (pd_active),
        .ref_stb (ref_stb),
        .vco_stb (vco_stb),
        .err_q   (err_q)
    );

    assign idle  = ~err_active(err_q);
    assign drive = orient(err_q, pos_slope);

    pfd_pd_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .pd_req      (pd_req),
        .peer_pd_req (peer_pd_req),
        .pump_idle   (idle),
        .pd_active   (pd_active),
        .div_en      (div_en),
        .shared_off  (shared_off)
    );

    pfd_lock_monitor #(
        .LOCK_CYCLES  (LOCK_CYCLES),
        .WIDTH_THRESH (WIDTH_THRESH)
    ) u_lock (
        .clk    (clk),
        .rst    (rst),
        .clear  (pd_active),
        .active (~idle),
        .lock_o (lock_det)
    );

    assign pump_up  = drive.up & ~force_hiz;
    assign pump_dn  = drive.dn & ~force_hiz;
    assign pump_hiz = force_hiz | idle;

    // R1: a reference strobe on a running, non-overlapping detector arms the up flag
    assert_ref_arms_R1: assert property (@(posedge clk) disable iff (rst)
        (ref_stb && !pd_active && !(err_q.up && err_q.dn)) |=> err_q.up);

    // R9: the shared disable is never raised while this divider still runs
    assert_shared_off_R9: assert property (@(posedge clk) disable iff (rst)
        shared_off |-> !div_en);

endmodule

// File: tb/pfd_gated_test.sv
`timescale 1ns/1ps
module pfd_gated_test;

    logic clk = 1'b0;
    logic rst, ref_stb, vco_stb, pos_slope, force_hiz, pd_req, peer_pd_req;
    logic pump_up, pump_dn, pump_hiz, lock_det, div_en, shared_off;
    int   n_run  = 0;
    int   n_fail = 0;
    logic done   = 1'b0;

    always #2.5 clk = ~clk;

    pfd_gated uut (
        .clk(clk), .rst(rst), .ref_stb(ref_stb), .vco_stb(vco_stb),
        .pos_slope(pos_slope), .force_hiz(force_hiz), .pd_req(pd_req),
        .peer_pd_req(peer_pd_req), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_hiz(pump_hiz), .lock_det(lock_det), .div_en(div_en),
        .shared_off(shared_off)
    );

    // {ref, vco, pos_slope, force_hiz, exp_up, exp_dn, exp_hiz}
    localparam logic [6:0] VEC [17] = '{
        7'b1010100, // R1 ref arms up
        7'b0110110, // R2 both set
        7'b0010001, // R2 cleared, R6 idle
        7'b1110110, // R2 simultaneous
        7'b0010001,
        7'b0110010, // R1 vco arms dn
        7'b0000100, // R4 swapped
        7'b1000110, // R4 both
        7'b0000001,
        7'b1011001, // R5 forced
        7'b0010100, // R5 state kept
        7'b0110110,
        7'b0010001,
        7'b1010100, // R3 first ref
        7'b1010100, // R3 repeat ref no change
        7'b0110110, // R3 single vco meets
        7'b0010001
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic r, input logic v);
        ref_stb = r;
        vco_stb = v;
        @(posedge clk);
        #1;
        ref_stb = 1'b0;
        vco_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        ref_stb = 0; vco_stb = 0; pos_slope = 1; force_hiz = 0;
        pd_req = 0; peer_pd_req = 0; rst = 1;
        @(posedge clk);
        #1;
        @(posedge clk);
        #1;
        // R13 reset state
        chk("R13 up",     {31'd0, pump_up},    0);
        chk("R13 dn",     {31'd0, pump_dn},    0);
        chk("R13 hiz",    {31'd0, pump_hiz},   1);
        chk("R13 lock",   {31'd0, lock_det},   0);
        chk("R13 div_en", {31'd0, div_en},     1);
        chk("R13 shared", {31'd0, shared_off}, 0);
        rst = 0;

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < 17; i++) begin
            pos_slope = VEC[i][4];
            force_hiz = VEC[i][3];
            tick(VEC[i][6], VEC[i][5]);
            chk($sformatf("R1/R2/R3/R4/R5/R6 row %0d pump", i),
                {29'd0, pump_up, pump_dn, pump_hiz}, {29'd0, VEC[i][2:0]});
        end
        pos_slope = 1; force_hiz = 0;

        // Lock acquisition R10
        do_reset();
        for (int k = 0; k < 7; k++) begin
            tick(1, 1); tick(0, 0); tick(0, 0);
        end
        chk("R10 no lock after 7", {31'd0, lock_det}, 0);
        tick(1, 1); tick(0, 0); tick(0, 0);
        chk("R10 lock after 8", {31'd0, lock_det}, 1);
        // R11 narrow low during pulse
        tick(1, 1);
        chk("R11 low in pulse", {31'd0, lock_det}, 0);
        tick(0, 0);
        chk("R11 high after pulse", {31'd0, lock_det}, 1);
        tick(0, 0);
        // R12 wide pulse drops lock
        tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 0);
        tick(0, 1); tick(0, 0); tick(0, 0);
        chk("R12 lock lost", {31'd0, lock_det}, 0);
        tick(1, 1); tick(0, 0); tick(0, 0);
        chk("R12 count restarted", {31'd0, lock_det}, 0);

        // Power-down deferral R7 R8 R9
        do_reset();
        tick(1, 0);
        pd_req = 1;
        tick(0, 0);
        chk("R7 busy keeps div_en", {31'd0, div_en}, 1);
        tick(0, 1);
        chk("R7 overlap keeps div_en", {31'd0, div_en}, 1);
        tick(0, 0);
        chk("R7 clearing edge keeps div_en", {31'd0, div_en}, 1);
        tick(0, 0);
        chk("R7 idle then down", {31'd0, div_en}, 0);
        chk("R9 peer off", {31'd0, shared_off}, 0);
        peer_pd_req = 1;
        #1;
        chk("R9 both down", {31'd0, shared_off}, 1);
        tick(1, 0);
        chk("R8 ref ignored", {30'd0, pump_up, pump_hiz}, 32'd1);
        tick(0, 1);
        chk("R8 vco ignored", {30'd0, pump_dn, pump_hiz}, 32'd1);
        pd_req = 0;
        tick(0, 0);
        chk("R8 div_en restored", {31'd0, div_en}, 1);
        chk("R9 shared cleared", {31'd0, shared_off}, 0);
        tick(1, 0);
        chk("R8 detector works", {31'd0, pump_up}, 1);
        peer_pd_req = 0;
        tick(0, 1); tick(0, 0);
        // R7 immediate entry when already idle
        pd_req = 1;
        tick(0, 0);
        chk("R7 idle entry", {31'd0, div_en}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule